// File: doc/BRIEF.md
# Runahead Store-to-Load Forwarding Cache

While a core runs ahead past a long-latency miss, its stores must not reach memory, yet later loads in the same runahead episode still need the values those stores produced. This block is a small direct-mapped buffer that holds such speculative store data, each word tagged with an INV flag, and resolves every runahead load in one combinational pass. A load never stalls here: a value that cannot be resolved comes back marked INV.

A load with a valid address is resolved in this order: first the store-buffer probe result, then this cache, then the memory-side hit indication. A committed store with a valid address fills the line at its index. Its data INV flag travels with the data. A committed store whose address is INV is dropped. Asserting the clear input when runahead ends empties the cache, so nothing written during the episode survives it. The block has no memory write port.

Top module: `ra_fwd_cache`

## Requirements
- R1: A load whose address-INV flag is set returns INV with source code 0 (address invalid) and data 0, whatever the store buffer, cache or memory inputs show.
- R2: A load with a valid address that hits the store-buffer probe returns source code 1 and the probe data, even when the cache or memory would also hit. If the probe's data-INV flag is set, the result is INV with data 0.
- R3: A load that misses the store buffer and the cache takes source code 3. On a memory hit it returns the memory data as valid. On a memory miss it returns INV with data 0 and no stall.
- R4: A committed store whose address-INV flag is set leaves the cache unchanged, so a later load to that address misses the cache.
- R5: A committed store with a valid address writes the line at index = address[IDX_W-1:0], and the tag = remaining upper bits. A later load to that address returns the data with source code 2 ahead of memory.
- R6: The line keeps the store's data-INV flag. A load that hits such a line returns INV with source code 2 and data 0.
- R7: The cache is direct-mapped. A store to an index already holding a different tag replaces that line, so the old address then misses.
- R8: While clear is high, stores are dropped and loads miss the cache. From the next cycle every line is invalid.
- R9: A store and a load presented in the same cycle to the same index give the load the store's line. The load returns the store data if the addresses match and misses the cache if the tags differ.
- R10: After synchronous active-low reset every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Runahead exit: invalidate all lines |
| st_vld_i | input | 1 | Store commit strobe |
| st_addr_i | input | ADDR_W | Store word address |
| st_addr_inv_i | input | 1 | Store address is INV |
| st_data_i | input | DATA_W | Store data |
| st_data_inv_i | input | 1 | Store data is INV |
| ld_vld_i | input | 1 | Load lookup strobe |
| ld_addr_i | input | ADDR_W | Load word address |
| ld_addr_inv_i | input | 1 | Load address is INV |
| sb_hit_i | input | 1 | Store-buffer probe hit |
| sb_data_i | input | DATA_W | Store-buffer probe data |
| sb_data_inv_i | input | 1 | Store-buffer probe data is INV |
| mem_hit_i | input | 1 | Memory-side cache hit |
| mem_data_i | input | DATA_W | Memory-side cache data |
| ld_data_o | output | DATA_W | Load result data (0 when INV) |
| ld_inv_o | output | 1 | Load result is INV |
| ld_src_o | output | 2 | Result source: 0 addr INV, 1 store buffer, 2 cache, 3 memory |

## Verification
On every cycle the assertions check the following:
- the lookup order of a load: an INV address short-circuits, a store-buffer hit wins, and a miss everywhere yields INV;
- that a dropped store leaves the valid bits unchanged;
- that a valid store installs its tag;
- that clear empties the array on the next cycle.

Only the bench's scenarios can show the rest:
- that stored data actually returns on a later load;
- that the data-INV flag survives in a line;
- conflict replacement at one index;
- the same-cycle store-to-load bypass for both matching and differing tags;
- that entries written before a clear are gone afterwards.

// File: rtl/ra_pkg.sv
// Shared definitions for the runahead forwarding cache.
// Assumes: load result source is a 2-bit code visible at the top ports.
package ra_pkg;
    typedef enum logic [1:0] {
        SRC_ADDR_INV = 2'd0,
        SRC_STBUF    = 2'd1,
        SRC_RACACHE  = 2'd2,
        SRC_MEMORY   = 2'd3
    } ld_src_e;
endpackage

// File: rtl/ra_line_array.sv
// Direct-mapped line storage: one valid bit, tag, data word and INV bit per line.
// A write and a read at the same index in one cycle return the written line.
// A clear empties all lines on the next edge and hides them during its own cycle.
// Assumes: wr_en_i is already gated by the caller for INV addresses and clear.
module ra_line_array #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_inv_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_inv_o
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  inv_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line update: reset or clear invalidates; a matching write fills.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                valid_q[g] <= 1'b0;
                inv_q[g]   <= 1'b0;
                tag_q[g]   <= '0;
                data_q[g]  <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                inv_q[g]   <= wr_inv_i;
                tag_q[g]   <= wr_tag_i;
                data_q[g]  <= wr_data_i;
            end
        end
    end

    // Read port with same-cycle write bypass and clear masking.
    always_comb begin
        if (wr_en_i && (wr_idx_i == rd_idx_i)) begin
            rd_valid_o = 1'b1;
            rd_tag_o   = wr_tag_i;
            rd_data_o  = wr_data_i;
            rd_inv_o   = wr_inv_i;
        end else begin
            rd_valid_o = valid_q[rd_idx_i] && !clr_i;
            rd_tag_o   = tag_q[rd_idx_i];
            rd_data_o  = data_q[rd_idx_i];
            rd_inv_o   = inv_q[rd_idx_i];
        end
    end

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (valid_q == '0));

    assert_store_fills_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> (valid_q[$past(wr_idx_i)] && (tag_q[$past(wr_idx_i)] == $past(wr_tag_i))));
endmodule

// File: rtl/ra_load_resolve.sv
// Combinational lookup priority for one runahead load:
// INV address, then store buffer, then runahead cache, then memory.
// Never stalls; anything unresolved is returned as INV with zero data.
// Assumes: cache hit already includes the tag compare.
module ra_load_resolve
    import ra_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_vld_i,
    input  logic              addr_inv_i,
    input  logic              sb_hit_i,
    input  logic [DATA_W-1:0] sb_data_i,
    input  logic              sb_inv_i,
    input  logic              rac_hit_i,
    input  logic [DATA_W-1:0] rac_data_i,
    input  logic              rac_inv_i,
    input  logic              mem_hit_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              inv_o,
    output ld_src_e           src_o
);
    logic [DATA_W-1:0] raw_data;
    logic              raw_inv;

    // Priority selection of source, raw data and INV flag.
    always_comb begin
        if (addr_inv_i) begin
            src_o = SRC_ADDR_INV; raw_data = '0;        raw_inv = 1'b1;
        end else if (sb_hit_i) begin
            src_o = SRC_STBUF;    raw_data = sb_data_i;  raw_inv = sb_inv_i;
        end else if (rac_hit_i) begin
            src_o = SRC_RACACHE;  raw_data = rac_data_i; raw_inv = rac_inv_i;
        end else begin
            src_o = SRC_MEMORY;   raw_data = mem_data_i; raw_inv = !mem_hit_i;
        end
    end

    // Output gating: no load means a quiet result; INV data reads as zero.
    always_comb begin
        inv_o  = ld_vld_i && raw_inv;
        data_o = (ld_vld_i && !raw_inv) ? raw_data : '0;
    end

    assert_addr_inv_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_i && addr_inv_i) |-> (inv_o && (src_o == SRC_ADDR_INV) && (data_o == '0)));

    assert_stbuf_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_i && !addr_inv_i && sb_hit_i) |-> (src_o == SRC_STBUF));

    assert_all_miss_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_i && !addr_inv_i && !sb_hit_i && !rac_hit_i && !mem_hit_i) |-> (inv_o && (src_o == SRC_MEMORY)));
endmodule

// File: rtl/ra_fwd_cache.sv
// Runahead store-to-load forwarding cache (top).
// Splits addresses into index and tag, gates stores whose address is INV,
// performs the tag compare and hands the load to the priority resolver.
// Assumes: word addresses; at most one store commit and one load per cycle.
module ra_fwd_cache
    import ra_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              st_vld_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              st_addr_inv_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              st_data_inv_i,
    input  logic              ld_vld_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              ld_addr_inv_i,
    input  logic              sb_hit_i,
    input  logic [DATA_W-1:0] sb_data_i,
    input  logic              sb_data_inv_i,
    input  logic              mem_hit_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              ld_inv_o,
    output logic [1:0]        ld_src_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              wr_en;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              rd_inv;
    logic              rac_hit;
    ld_src_e           src;

    // Store gate: INV-address stores and stores during clear are dropped.
    always_comb wr_en = st_vld_i && !st_addr_inv_i && !clr_i;

    ra_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .wr_en_i    (wr_en),
        .wr_idx_i   (st_addr_i[IDX_W-1:0]),
        .wr_tag_i   (st_addr_i[ADDR_W-1:IDX_W]),
        .wr_data_i  (st_data_i),
        .wr_inv_i   (st_data_inv_i),
        .rd_idx_i   (ld_addr_i[IDX_W-1:0]),
        .rd_valid_o (rd_valid),
        .rd_tag_o   (rd_tag),
        .rd_data_o  (rd_data),
        .rd_inv_o   (rd_inv)
    );

    // Tag compare against the selected line.
    always_comb rac_hit = rd_valid && (rd_tag == ld_addr_i[ADDR_W-1:IDX_W]);

    ra_load_resolve #(.DATA_W(DATA_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_vld_i   (ld_vld_i),
        .addr_inv_i (ld_addr_inv_i),
        .sb_hit_i   (sb_hit_i),
        .sb_data_i  (sb_data_i),
        .sb_inv_i   (sb_data_inv_i),
        .rac_hit_i  (rac_hit),
        .rac_data_i (rd_data),
        .rac_inv_i  (rd_inv),
        .mem_hit_i  (mem_hit_i),
        .mem_data_i (mem_data_i),
        .data_o     (ld_data_o),
        .inv_o      (ld_inv_o),
        .src_o      (src)
    );

    // Source code to plain port.
    always_comb ld_src_o = src;

    assert_inv_store_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld_i && st_addr_inv_i) |=> $stable(u_arr.valid_q));
endmodule

// File: tb/ra_fwd_cache_bench.sv
// Scoreboard bench: the driver pushes expected load results, the monitor
// pops and compares them 1 ns after each falling edge.
module ra_fwd_cache_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_i = 1'b0;
    logic              st_vld_i = 1'b0, st_addr_inv_i = 1'b0, st_data_inv_i = 1'b0;
    logic [ADDR_W-1:0] st_addr_i = '0, ld_addr_i = '0;
    logic [DATA_W-1:0] st_data_i = '0, sb_data_i = '0, mem_data_i = '0;
    logic              ld_vld_i = 1'b0, ld_addr_inv_i = 1'b0;
    logic              sb_hit_i = 1'b0, sb_data_inv_i = 1'b0, mem_hit_i = 1'b0;
    logic [DATA_W-1:0] ld_data_o;
    logic              ld_inv_o;
    logic [1:0]        ld_src_o;

    typedef struct {
        logic [DATA_W-1:0] d;
        logic              inv;
        logic [1:0]        src;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #2 clk = ~clk;

    ra_fwd_cache u_ra_fwd_cache (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .st_vld_i(st_vld_i), .st_addr_i(st_addr_i), .st_addr_inv_i(st_addr_inv_i),
        .st_data_i(st_data_i), .st_data_inv_i(st_data_inv_i),
        .ld_vld_i(ld_vld_i), .ld_addr_i(ld_addr_i), .ld_addr_inv_i(ld_addr_inv_i),
        .sb_hit_i(sb_hit_i), .sb_data_i(sb_data_i), .sb_data_inv_i(sb_data_inv_i),
        .mem_hit_i(mem_hit_i), .mem_data_i(mem_data_i),
        .ld_data_o(ld_data_o), .ld_inv_o(ld_inv_o), .ld_src_o(ld_src_o)
    );

    // Driver: one cycle of stimulus; a load also pushes its expected result.
    task automatic cyc(input logic clr, input logic sv, input logic [ADDR_W-1:0] sa,
                       input logic sai, input logic [DATA_W-1:0] sd, input logic sdi,
                       input logic lv, input logic [ADDR_W-1:0] la, input logic lai,
                       input logic sbh, input logic [DATA_W-1:0] sbd, input logic sbi,
                       input logic mh, input logic [DATA_W-1:0] md,
                       input logic [DATA_W-1:0] ed, input logic einv, input logic [1:0] esrc,
                       input string req);
        exp_t e;
        @(negedge clk);
        clr_i = clr; st_vld_i = sv; st_addr_i = sa; st_addr_inv_i = sai;
        st_data_i = sd; st_data_inv_i = sdi;
        ld_vld_i = lv; ld_addr_i = la; ld_addr_inv_i = lai;
        sb_hit_i = sbh; sb_data_i = sbd; sb_data_inv_i = sbi;
        mem_hit_i = mh; mem_data_i = md;
        if (lv) begin
            e.d = ed; e.inv = einv; e.src = esrc; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic store(input logic [ADDR_W-1:0] a, input logic ai,
                         input logic [DATA_W-1:0] d, input logic di);
        cyc(0, 1, a, ai, d, di, 0, '0, 0, 0, '0, 0, 0, '0, '0, 0, 0, "");
    endtask

    task automatic load(input logic [ADDR_W-1:0] a, input logic ai,
                        input logic sbh, input logic [DATA_W-1:0] sbd, input logic sbi,
                        input logic mh, input logic [DATA_W-1:0] md,
                        input logic [DATA_W-1:0] ed, input logic einv, input logic [1:0] esrc,
                        input string req);
        cyc(0, 0, '0, 0, '0, 0, 1, a, ai, sbh, sbd, sbi, mh, md, ed, einv, esrc, req);
    endtask

    // Monitor: compares the combinational result well before the next edge.
    always @(negedge clk) begin
        #1;
        if (ld_vld_i && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (ld_data_o !== e.d || ld_inv_o !== e.inv || ld_src_o !== e.src) begin
                bad++;
                $display("FAIL %s: got data=%h inv=%b src=%0d, expected data=%h inv=%b src=%0d",
                         e.req, ld_data_o, ld_inv_o, ld_src_o, e.d, e.inv, e.src);
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: empty after reset -> memory miss gives INV
        load(16'h0010, 0, 0, '0, 0, 0, 32'h77, '0, 1, 2'd3, "R10");
        // R3: memory hit valid, memory miss INV
        load(16'h0020, 0, 0, '0, 0, 1, 32'hAAAA, 32'hAAAA, 0, 2'd3, "R3");
        load(16'h0021, 0, 0, '0, 0, 0, 32'hBBBB, '0, 1, 2'd3, "R3");
        // R1: INV address overrides store-buffer and memory hits
        load(16'h0020, 1, 1, 32'h1234, 0, 1, 32'h5, '0, 1, 2'd0, "R1");
        // R5: store then load hits cache ahead of memory
        store(16'h0011, 0, 32'h1111, 0);
        load(16'h0011, 0, 0, '0, 0, 1, 32'h9, 32'h1111, 0, 2'd2, "R5");
        // R2: store buffer wins over cache; INV store-buffer data
        load(16'h0011, 0, 1, 32'h2222, 0, 1, 32'h9, 32'h2222, 0, 2'd1, "R2");
        load(16'h0011, 0, 1, 32'h2222, 1, 1, 32'h9, '0, 1, 2'd1, "R2");
        // R4: INV-address store dropped
        store(16'h0012, 1, 32'h3333, 0);
        load(16'h0012, 0, 0, '0, 0, 0, '0, '0, 1, 2'd3, "R4");
        // R6: INV data kept in the line
        store(16'h0013, 0, 32'h6666, 1);
        load(16'h0013, 0, 0, '0, 0, 1, 32'h8, '0, 1, 2'd2, "R6");
        // R7: conflict at index 1 replaces 0x0011
        store(16'h0019, 0, 32'h4444, 0);
        load(16'h0011, 0, 0, '0, 0, 1, 32'h5, 32'h5, 0, 2'd3, "R7");
        load(16'h0019, 0, 0, '0, 0, 0, '0, 32'h4444, 0, 2'd2, "R7");
        // R9: same-cycle store and load, same address then same index other tag
        cyc(0, 1, 16'h0014, 0, 32'h5555, 0, 1, 16'h0014, 0, 0, '0, 0, 0, '0,
            32'h5555, 0, 2'd2, "R9");
        cyc(0, 1, 16'h001C, 0, 32'hCCCC, 0, 1, 16'h0014, 0, 0, '0, 0, 0, '0,
            '0, 1, 2'd3, "R9");
        load(16'h001C, 0, 0, '0, 0, 0, '0, 32'hCCCC, 0, 2'd2, "R9");
        // R8: clear cycle with store and load; lookups miss, store dropped
        cyc(1, 1, 16'h0015, 0, 32'hDDDD, 0, 1, 16'h001C, 0, 0, '0, 0, 0, '0,
            '0, 1, 2'd3, "R8");
        load(16'h0019, 0, 0, '0, 0, 0, '0, '0, 1, 2'd3, "R8");
        load(16'h0015, 0, 0, '0, 0, 0, '0, '0, 1, 2'd3, "R8");
        load(16'h001C, 0, 0, '0, 0, 1, 32'hE, 32'hE, 0, 2'd3, "R8");
        cyc(0, 0, '0, 0, '0, 0, 0, '0, 0, 0, '0, 0, 0, '0, '0, 0, 0, "");
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard: got %0d pending, expected 0", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule